// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This block is a slave on a processor's 16-bit word memory bus. It claims two word addresses, a keyboard status word at 0xFE00 and a keyboard data word at 0xFE02. Every other access goes through to the downstream memory port without change. Characters arrive one byte at a time on a valid/ready stream. A one-entry holding buffer keeps the newest accepted byte until the processor collects it.

The processor polls the status word. Each status read is computed fresh from the state of the holding buffer. If a byte is waiting, the read returns the ready flag in bit 15, and the byte moves into the data word, which frees the buffer. The processor then reads the data word, which keeps its value until a later status read replaces it. The bus response is combinational in the same cycle as the request, and all state changes at the following clock edge.

Top module: `kbd_port`

## Requirements
- R1: A read of 0xFE00 while the holding buffer is full returns 0x8000, that is, only bit 15 set.
- R2: A read of 0xFE00 while the holding buffer is empty returns 0x0000.
- R3: A read of 0xFE00 that finds a byte waiting copies that byte into the data word at the next clock edge, zero-extended to 16 bits, so bits 15..8 are 0 even when bit 7 of the byte is set.
- R4: A read of 0xFE02 returns the data word. Repeated reads, and status reads that find the buffer empty, leave the data word unchanged.
- R5: in_ready is high exactly when the holding buffer is empty. A byte is taken on a clock edge where in_valid and in_ready are both high. While the buffer is full, in_valid has no effect and the buffered byte is kept.
- R6: A status read that latches a byte empties the buffer, so in_ready is high in the next cycle.
- R7: An access to any address other than 0xFE00 and 0xFE02 is forwarded in the same cycle. mem_req, mem_we, mem_addr and mem_wdata equal the processor's request, and cpu_rdata equals mem_rdata.
- R8: An access to 0xFE00 or 0xFE02 is not forwarded: mem_req stays low.
- R9: Writes to 0xFE00 or 0xFE02 are ignored. They change neither the data word nor the holding buffer.
- R10: After a synchronous active-low reset, the buffer is empty, in_ready is high and the data word is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Read data returned to the processor |
| mem_req | output | 1 | Forwarded access strobe |
| mem_we | output | 1 | Forwarded write enable |
| mem_addr | output | 16 | Forwarded address |
| mem_wdata | output | 16 | Forwarded write data |
| mem_rdata | input | 16 | Read data from downstream memory |
| in_valid | input | 1 | Incoming byte is valid |
| in_byte | input | 8 | Incoming character byte |
| in_ready | output | 1 | Holding buffer can take a byte |

## Verification
The bench offers a new byte in the same cycle that a status read drains the buffer. A design that reported ready one cycle early would either lose the new byte or overwrite the byte being latched. It latches a byte with bit 7 set to catch sign extension, and rereads the data word after an empty status read to catch a design that clears the data word instead of only the status. It writes both claimed addresses while a byte is waiting, which exposes a decoder that treats writes as reads and drains the buffer. It also reads the addresses next to the claimed ones, which would be swallowed by a decoder that ignores bit 0 or bit 1.

// File: rtl/kbd_pkg.sv
// Shared definitions for the keyboard input port.
// Assumes a 16-bit word address space and 16-bit data words.
package kbd_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned CHAR_W = 8;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00;
    localparam logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02;

    // Which local word an access targets, if any.
    typedef enum logic [1:0] {
        TGT_MEM  = 2'd0,
        TGT_STAT = 2'd1,
        TGT_DATA = 2'd2
    } kbd_tgt_e;
endpackage

// File: rtl/kbd_decode.sv
// Address decoder: classifies each processor access as local status,
// local data, or pass-through. Assumes exact, full-width address match.
module kbd_decode
    import kbd_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter logic [AW-1:0] ST_ADDR = STAT_ADDR,
    parameter logic [AW-1:0] DT_ADDR = DATA_ADDR
) (
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    output kbd_tgt_e      tgt,
    output logic          stat_rd,
    output logic          fwd
);
    // Pick the target of the current address.
    always_comb begin
        if (addr == ST_ADDR)      tgt = TGT_STAT;
        else if (addr == DT_ADDR) tgt = TGT_DATA;
        else                      tgt = TGT_MEM;
    end

    // Qualify: a status read refreshes state; misses go downstream.
    always_comb begin
        stat_rd = req && !we && (tgt == TGT_STAT);
        fwd     = req && (tgt == TGT_MEM);
    end
endmodule

// File: rtl/kbd_hold_buf.sv
// One-entry holding buffer for incoming bytes. Takes a byte only while
// empty; empties when the consumer pops it. Assumes pop is only raised
// while full or has no effect otherwise.
module kbd_hold_buf #(
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [BW-1:0] in_byte,
    output logic          in_ready,
    input  logic          pop,
    output logic          full,
    output logic [BW-1:0] held
);
    logic take;

    // Accept handshake only while empty.
    always_comb begin
        in_ready = !full;
        take     = in_valid && in_ready;
    end

    // Track occupancy and hold the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (take) begin
            full <= 1'b1;
            held <= in_byte;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

    a_r5_take_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && held == $past(in_byte)));
    a_r5_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (full && $stable(held)));
    a_r6_pop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pop) |=> in_ready);
endmodule

// File: rtl/kbd_data_reg.sv
// Data word: captures a zero-extended byte on latch and holds it
// otherwise. Assumes WW >= BW.
module kbd_data_reg #(
    parameter int unsigned WW = 16,
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch,
    input  logic [BW-1:0] byte_in,
    output logic [WW-1:0] word_q
);
    localparam int unsigned PAD_W = WW - BW;

    // Capture the byte with zero padding when asked.
    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= '0;
        else if (latch) word_q <= {{PAD_W{1'b0}}, byte_in};
    end

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(word_q));
    a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (word_q[WW-1:BW] == '0));
endmodule

// File: rtl/kbd_port.sv
// Keyboard input port on the processor word bus. Claims the status and
// data words, forwards all else downstream combinationally. Assumes a
// single-cycle bus where the response is taken in the request cycle.
module kbd_port
    import kbd_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned WW = WORD_W,
    parameter int unsigned BW = CHAR_W,
    parameter logic [AW-1:0] ST_ADDR = STAT_ADDR,
    parameter logic [AW-1:0] DT_ADDR = DATA_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [WW-1:0] cpu_wdata,
    output logic [WW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    input  logic [WW-1:0] mem_rdata,
    input  logic          in_valid,
    input  logic [BW-1:0] in_byte,
    output logic          in_ready
);
    localparam int unsigned RDY_BIT = WW - 1;

    kbd_tgt_e      tgt;
    logic          stat_rd;
    logic          fwd;
    logic          full;
    logic [BW-1:0] held;
    logic          latch;
    logic [WW-1:0] data_q;
    logic [WW-1:0] stat_word;

    kbd_decode #(.AW(AW), .ST_ADDR(ST_ADDR), .DT_ADDR(DT_ADDR)) u_dec (
        .req(cpu_req), .we(cpu_we), .addr(cpu_addr),
        .tgt(tgt), .stat_rd(stat_rd), .fwd(fwd)
    );

    kbd_hold_buf #(.BW(BW)) u_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .pop(latch), .full(full), .held(held)
    );

    kbd_data_reg #(.WW(WW), .BW(BW)) u_data (
        .clk(clk), .rst_n(rst_n), .latch(latch), .byte_in(held),
        .word_q(data_q)
    );

    // A status read moves a waiting byte into the data word.
    always_comb latch = stat_rd && full;

    // Build the freshly refreshed status word.
    always_comb begin
        stat_word          = '0;
        stat_word[RDY_BIT] = full;
    end

    // Drive the downstream port; gate the strobe on a local hit.
    always_comb begin
        mem_req   = fwd;
        mem_we    = cpu_we;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
    end

    // Select the read response.
    always_comb begin
        unique case (tgt)
            TGT_STAT: cpu_rdata = stat_word;
            TGT_DATA: cpu_rdata = data_q;
            default:  cpu_rdata = mem_rdata;
        endcase
    end

    a_r8_local_not_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == ST_ADDR || cpu_addr == DT_ADDR) |-> !mem_req);
    a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && full) |=> (full && $stable(data_q)));
    a_r3_latch_value: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_addr == ST_ADDR && !in_ready)
        |=> (data_q[BW-1:0] == $past(held)));
    a_r2_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_addr == ST_ADDR && in_ready)
        |-> (cpu_rdata == '0));
endmodule

// File: tb/kbd_port_bench.sv
`timescale 1ns/1ps
module kbd_port_bench;
    localparam int NV = 14;
    localparam logic [15:0] MASK = 16'hA5A5;
    // {req, we, addr, wdata, in_valid, byte, exp_ready, exp_rdata}
    localparam logic [59:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 8'h41, 1'b1, 16'h0000},
        {1'b1, 1'b0, 16'hFE00, 16'h0000, 1'b1, 8'h42, 1'b0, 16'h8000},
        {1'b1, 1'b0, 16'hFE02, 16'h0000, 1'b0, 8'h00, 1'b1, 16'h0041},
        {1'b1, 1'b0, 16'hFE02, 16'h0000, 1'b0, 8'h00, 1'b1, 16'h0041},
        {1'b1, 1'b0, 16'hFE00, 16'h0000, 1'b0, 8'h00, 1'b1, 16'h0000},
        {1'b1, 1'b0, 16'hFE02, 16'h0000, 1'b0, 8'h00, 1'b1, 16'h0041},
        {1'b1, 1'b0, 16'h1234, 16'h0000, 1'b1, 8'hC3, 1'b1, 16'hB791},
        {1'b1, 1'b1, 16'hFE00, 16'hFFFF, 1'b0, 8'h00, 1'b0, 16'h0000},
        {1'b1, 1'b1, 16'hFE02, 16'h1234, 1'b0, 8'h00, 1'b0, 16'h0000},
        {1'b1, 1'b0, 16'hFE02, 16'h0000, 1'b0, 8'h00, 1'b0, 16'h0041},
        {1'b1, 1'b0, 16'hFE00, 16'h0000, 1'b1, 8'h55, 1'b0, 16'h8000},
        {1'b1, 1'b0, 16'hFE02, 16'h0000, 1'b0, 8'h00, 1'b1, 16'h00C3},
        {1'b1, 1'b0, 16'hFE01, 16'h0000, 1'b0, 8'h00, 1'b1, 16'h5BA4},
        {1'b1, 1'b1, 16'hFE03, 16'hBEEF, 1'b0, 8'h00, 1'b1, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        mem_req, mem_we, in_ready;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;
    assign mem_rdata = mem_addr ^ MASK;

    kbd_port u_kbd_port (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic rq, input logic w, input logic [15:0] a,
                         input logic [15:0] d, input logic v, input logic [7:0] b);
        @(negedge clk);
        cpu_req = rq; cpu_we = w; cpu_addr = a; cpu_wdata = d;
        in_valid = v; in_byte = b;
        #1;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R10: reset state
        chk("R10 ready after reset", {15'b0, in_ready}, 16'h0001);
        for (int i = 0; i < NV; i++) begin
            logic [59:0] v;
            logic        local_hit;
            v = VEC[i];
            drive(v[59], v[58], v[57:42], v[41:26], v[25], v[24:17]);
            local_hit = (v[57:42] == 16'hFE00) || (v[57:42] == 16'hFE02);
            // R5/R6: in_ready reflects emptiness
            chk($sformatf("R5 R6 in_ready step %0d", i), {15'b0, in_ready}, {15'b0, v[16]});
            // R8/R7: forwarding strobe
            chk($sformatf("R7 R8 mem_req step %0d", i), {15'b0, mem_req},
                {15'b0, v[59] && !local_hit});
            if (v[59] && !local_hit) begin
                chk($sformatf("R7 mem_addr step %0d", i), mem_addr, v[57:42]);
                chk($sformatf("R7 mem_wdata step %0d", i), mem_wdata, v[41:26]);
                chk($sformatf("R7 mem_we step %0d", i), {15'b0, mem_we}, {15'b0, v[58]});
            end
            // R1 R2 R3 R4 R9 R7: read data
            if (v[59] && !v[58])
                chk($sformatf("R1 R2 R3 R4 R9 rdata step %0d", i), cpu_rdata, v[15:0]);
        end
        // R5: push a byte, then reset while full
        drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 8'h7E);
        drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h00);
        chk("R5 full after push", {15'b0, in_ready}, 16'h0000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        drive(1'b1, 1'b0, 16'hFE00, 16'h0, 1'b0, 8'h00);
        chk("R10 ready after mid-run reset", {15'b0, in_ready}, 16'h0001);
        chk("R10 status after reset", cpu_rdata, 16'h0000);
        drive(1'b1, 1'b0, 16'hFE02, 16'h0, 1'b0, 8'h00);
        chk("R10 data word cleared", cpu_rdata, 16'h0000);
        // R6: back-to-back latch then empty status
        drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 8'h80);
        drive(1'b1, 1'b0, 16'hFE00, 16'h0, 1'b0, 8'h00);
        chk("R1 status with byte", cpu_rdata, 16'h8000);
        drive(1'b1, 1'b0, 16'hFE00, 16'h0, 1'b0, 8'h00);
        chk("R6 status after drain", cpu_rdata, 16'h0000);
        drive(1'b1, 1'b0, 16'hFE02, 16'h0, 1'b0, 8'h00);
        chk("R3 zero-extended 0x80", cpu_rdata, 16'h0080);
        drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule